// File: doc/BRIEF.md
# Chained Integer Min/Max Execution Unit

This unit carries out one video-style integer min/max instruction per strobe. It takes a 64-bit instruction word and three 32-bit register values, called A, B and C. It first forms the minimum or the maximum of A and B, using either a signed or an unsigned compare. A second stage then combines that primary result with C in one of three ways: by splicing it into a fixed bit slice of C, by adding C to it, or by a further min or max against C. The second compare has a signedness choice of its own.

The final value is registered and reported one clock after the input strobe, together with a valid flag. A companion flag marks an instruction word that the unit does not fully handle. Such a word is one that was not recognised, or one that asks for sub-word sources, saturation, a non-register B operand or mixed source signedness. The value computed for such a word is still delivered, worked out as if those control bits were clear, so the issuing logic can decide what to do with it.

Top module: `mmx_unit`

## Requirements
- R1: An instruction word is recognised only when bits 63:57 equal 7'b0011101; any other value there sets `unsupported` for that result.
- R2: Bit 56 selects the primary operation: 1 gives the larger of A and B, 0 gives the smaller.
- R3: Bit 48 set makes the primary compare treat A and B as two's-complement signed values; bit 48 clear makes it unsigned.
- R4: Bits 53:51 select the second stage. Codes 0 to 3 splice into C and keep every other bit of C: code 0 puts primary[15:0] into C[31:16], code 1 puts primary[15:0] into C[15:0], code 2 puts primary[7:0] into C[7:0], and code 3 puts primary[7:0] into C[23:16].
- R5: Code 4 gives primary + C modulo 2^32; code 7 gives the primary result unchanged.
- R6: Code 5 gives the smaller and code 6 the larger of the primary result and C. The compare is signed when bit 54 is set and unsigned otherwise, whatever the value of bit 48.
- R7: The source-format fields at bits 38:37 (A) and 30:29 (B) read 2'b11 as 32-bit, 2'b10 as 16-bit and any other value as 8-bit. Any format other than 32-bit sets `unsupported`.
- R8: `unsupported` is also set when bit 50 is 0 (B not from a register), when bit 48 differs from bit 49, or when bit 55 (saturate) is 1. The result is still the value computed with those bits ignored.
- R9: `res_valid`, `result` and `unsupported` update on the first rising clock edge after one on which `in_valid` is high.
- R10: After an edge on which `in_valid` is low, `res_valid` is 0 and `result` and `unsupported` keep their previous values.
- R11: While `rst` is high at a rising edge, `res_valid`, `result` and `unsupported` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction word are present |
| instr | input | 64 | Instruction word |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| opc | input | 32 | Operand C, the second-stage operand |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 32 | Registered final value |
| unsupported | output | 1 | Registered flag for an unrecognised or partly handled word |

## Verification
Every result is due exactly one rising edge after the edge that samples `in_valid`, because the decode and both compute stages are combinational in front of a single output register. The bench drives its inputs on a falling edge and removes the strobe on the next falling edge. It reads `res_valid`, `result` and `unsupported` at that second falling edge, half a period after the capturing edge. The hold checks for R10 read the outputs on falling edges again after further idle edges, with the inputs scrambled in between.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

    localparam int DATA_W  = 32;
    localparam int INSTR_W = 64;

    // Field positions inside the instruction word
    localparam int POS_MAXSEL  = 56;
    localparam int POS_SAT     = 55;
    localparam int POS_DST_SGN = 54;
    localparam int POS_SEC_LO  = 51;
    localparam int POS_BREG    = 50;
    localparam int POS_B_SGN   = 49;
    localparam int POS_A_SGN   = 48;
    localparam int POS_FMTA_LO = 37;
    localparam int POS_FMTB_LO = 29;
    localparam int OPC_W       = 7;
    localparam int OPC_LO      = INSTR_W - OPC_W;
    localparam logic [OPC_W-1:0] OPC_MATCH = 7'b0011101;

    typedef enum logic [1:0] {
        SW_8  = 2'd0,
        SW_16 = 2'd1,
        SW_32 = 2'd2
    } width_e;

    typedef enum logic [2:0] {
        SEC_INS_HI16 = 3'd0,
        SEC_INS_LO16 = 3'd1,
        SEC_INS_B0   = 3'd2,
        SEC_INS_B2   = 3'd3,
        SEC_ACC      = 3'd4,
        SEC_MIN      = 3'd5,
        SEC_MAX      = 3'd6,
        SEC_PASS     = 3'd7
    } sec_e;

    typedef struct packed {
        logic   opc_hit;
        logic   take_max;
        logic   a_signed;
        logic   b_signed;
        logic   dst_signed;
        logic   sat;
        logic   b_is_reg;
        sec_e   sec;
        width_e fmt_a;
        width_e fmt_b;
    } ctrl_t;

    function automatic width_e fmt_decode(input logic [1:0] code);
        case (code)
            2'b11:   return SW_32;
            2'b10:   return SW_16;
            default: return SW_8;
        endcase
    endfunction

    function automatic logic is_less(input logic [DATA_W-1:0] x,
                                     input logic [DATA_W-1:0] y,
                                     input logic              sgn);
        if (sgn) return $signed(x) < $signed(y);
        return x < y;
    endfunction

    function automatic logic [DATA_W-1:0] pick(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y,
                                               input logic              sgn,
                                               input logic              want_max);
        logic x_lt_y;
        x_lt_y = is_less(x, y, sgn);
        if (want_max) return x_lt_y ? y : x;
        return x_lt_y ? x : y;
    endfunction

    function automatic logic [DATA_W-1:0] splice(input logic [DATA_W-1:0] base,
                                                 input logic [DATA_W-1:0] val,
                                                 input int                lsb,
                                                 input int                width);
        logic [DATA_W-1:0] mask;
        mask = ((DATA_W'(1) << width) - DATA_W'(1)) << lsb;
        return (base & ~mask) | ((val << lsb) & mask);
    endfunction

endpackage

// File: rtl/mmx_decode.sv
module mmx_decode
    import mmx_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl,
    output logic               unsup
);
    always_comb begin
        ctrl.opc_hit    = (instr[INSTR_W-1:OPC_LO] == OPC_MATCH);
        ctrl.take_max   = instr[POS_MAXSEL];
        ctrl.a_signed   = instr[POS_A_SGN];
        ctrl.b_signed   = instr[POS_B_SGN];
        ctrl.dst_signed = instr[POS_DST_SGN];
        ctrl.sat        = instr[POS_SAT];
        ctrl.b_is_reg   = instr[POS_BREG];
        ctrl.sec        = sec_e'(instr[POS_SEC_LO +: 3]);
        ctrl.fmt_a      = fmt_decode(instr[POS_FMTA_LO +: 2]);
        ctrl.fmt_b      = fmt_decode(instr[POS_FMTB_LO +: 2]);
    end

    always_comb begin
        unsup = !ctrl.opc_hit
              || !ctrl.b_is_reg
              || (ctrl.fmt_a != SW_32)
              || (ctrl.fmt_b != SW_32)
              || (ctrl.a_signed != ctrl.b_signed)
              || ctrl.sat;
    end

    always_comb begin
        AST_SAT_FLAGS: assert (!instr[POS_SAT] || unsup); // R8
        AST_FMT_FLAGS: assert ((instr[POS_FMTA_LO +: 2] == 2'b11 && instr[POS_FMTB_LO +: 2] == 2'b11) || unsup); // R7
    end
endmodule

// File: rtl/mmx_primary.sv
module mmx_primary
    import mmx_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sgn,
    input  logic              take_max,
    output logic [DATA_W-1:0] y
);
    always_comb y = pick(a, b, sgn, take_max);

    always_comb begin
        AST_PRI_OPERAND: assert (y == a || y == b); // R2
    end
endmodule

// File: rtl/mmx_secondary.sv
module mmx_secondary
    import mmx_pkg::*;
(
    input  logic [DATA_W-1:0] p,
    input  logic [DATA_W-1:0] c,
    input  sec_e              sec,
    input  logic              dst_signed,
    output logic [DATA_W-1:0] y
);
    localparam int HALF = DATA_W / 2;
    localparam int BYTE = 8;

    always_comb begin
        case (sec)
            SEC_INS_HI16: y = splice(c, p, HALF, HALF);
            SEC_INS_LO16: y = splice(c, p, 0, HALF);
            SEC_INS_B0:   y = splice(c, p, 0, BYTE);
            SEC_INS_B2:   y = splice(c, p, HALF, BYTE);
            SEC_ACC:      y = p + c;
            SEC_MIN:      y = pick(p, c, dst_signed, 1'b0);
            SEC_MAX:      y = pick(p, c, dst_signed, 1'b1);
            default:      y = p;
        endcase
    end

    always_comb begin
        AST_MERGE_KEEP: assert (sec != SEC_INS_B2 || (y[31:24] == c[31:24] && y[15:0] == c[15:0])); // R4
        AST_PASS_THRU:  assert (sec != SEC_PASS || y == p); // R5
    end
endmodule

// File: rtl/mmx_unit.sv
module mmx_unit
    import mmx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic [DATA_W-1:0]   opc,
    output logic                res_valid,
    output logic [DATA_W-1:0]   result,
    output logic                unsupported
);
    ctrl_t             ctrl;
    logic              unsup_c;
    logic [DATA_W-1:0] prim;
    logic [DATA_W-1:0] fin;

    mmx_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl),
        .unsup (unsup_c)
    );

    mmx_primary u_pri (
        .a        (opa),
        .b        (opb),
        .sgn      (ctrl.a_signed),
        .take_max (ctrl.take_max),
        .y        (prim)
    );

    mmx_secondary u_sec (
        .p          (prim),
        .c          (opc),
        .sec        (ctrl.sec),
        .dst_signed (ctrl.dst_signed),
        .y          (fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            result      <= '0;
            unsupported <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                result      <= fin;
                unsupported <= unsup_c;
            end
        end
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(unsupported))); // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!res_valid && result == '0 && !unsupported)); // R11
endmodule

// File: tb/mmx_unit_test.sv
`timescale 1ns/1ps
module mmx_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] instr;
    logic [31:0] opa, opb, opc;
    logic        res_valid;
    logic [31:0] result;
    logic        unsupported;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mmx_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .opa(opa), .opb(opb), .opc(opc),
        .res_valid(res_valid), .result(result), .unsupported(unsupported)
    );

    // Build an instruction word; supported defaults when caller passes them
    function automatic logic [63:0] mk(input logic mx, input logic [2:0] sop,
                                       input logic dsg, input logic sa, input logic sb,
                                       input logic sat, input logic breg,
                                       input logic [1:0] fa, input logic [1:0] fb);
        logic [63:0] w;
        w = 64'h0;
        w[63:57] = 7'b0011101;
        w[56] = mx; w[55] = sat; w[54] = dsg; w[53:51] = sop;
        w[50] = breg; w[49] = sb; w[48] = sa;
        w[38:37] = fa; w[30:29] = fb;
        return w;
    endfunction

    function automatic logic [63:0] ok(input logic mx, input logic [2:0] sop,
                                       input logic dsg, input logic sgn);
        return mk(mx, sop, dsg, sgn, sgn, 1'b0, 1'b1, 2'b11, 2'b11);
    endfunction

    // Reference model written from the requirements
    function automatic logic [31:0] ref_mm(input logic [31:0] x, input logic [31:0] y,
                                           input logic sgn, input logic mx);
        logic ylarger;
        if (sgn) ylarger = ($signed(y) > $signed(x));
        else     ylarger = (y > x);
        if (mx) return ylarger ? y : x;
        else    return ylarger ? x : y;
    endfunction

    function automatic logic [31:0] ref_val(input logic [63:0] w, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] c);
        logic [31:0] p;
        p = ref_mm(a, b, w[48], w[56]);
        case (w[53:51])
            3'd0: return {p[15:0], c[15:0]};
            3'd1: return {c[31:16], p[15:0]};
            3'd2: return {c[31:8], p[7:0]};
            3'd3: return {c[31:24], p[7:0], c[15:0]};
            3'd4: return p + c;
            3'd5: return ref_mm(p, c, w[54], 1'b0);
            3'd6: return ref_mm(p, c, w[54], 1'b1);
            default: return p;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one strobe, sample one edge later at the falling edge
    task automatic issue(input logic [63:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c,
                         input string req, input logic exp_unsup);
        @(negedge clk);
        instr = w; opa = a; opb = b; opc = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R9 valid"}, {31'b0, res_valid}, 32'd1);
        chk(req, result, ref_val(w, a, b, c));
        chk({req, " flag"}, {31'b0, unsupported}, {31'b0, exp_unsup});
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b1; instr = ok(1, 3'd7, 0, 0);
        opa = 32'h1234; opb = 32'h5678; opc = 32'h9;
        repeat (3) @(negedge clk);
        chk("R11 valid", {31'b0, res_valid}, 32'd0);
        chk("R11 result", result, 32'd0);
        chk("R11 flag", {31'b0, unsupported}, 32'd0);
        in_valid = 1'b0; rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_primary;
        logic [31:0] hi = 32'h7FFFFFFF, lo = 32'h80000000;
        issue(ok(1, 3'd7, 0, 0), hi, lo, 0, "R2 max unsigned", 0);
        chk("R3 unsigned max pick", result, lo);
        issue(ok(1, 3'd7, 0, 1), hi, lo, 0, "R3 max signed", 0);
        chk("R3 signed max pick", result, hi);
        issue(ok(0, 3'd7, 0, 0), hi, lo, 0, "R2 min unsigned", 0);
        chk("R2 unsigned min pick", result, hi);
        issue(ok(0, 3'd7, 0, 1), hi, lo, 0, "R3 min signed", 0);
        chk("R3 signed min pick", result, lo);
        issue(ok(0, 3'd7, 0, 1), 32'hFFFFFFFF, 32'd1, 0, "R3 minus one", 0);
    endtask

    task automatic t_secondary;
        for (int code = 0; code < 8; code++) begin
            for (int k = 0; k < 6; k++) begin
                logic [31:0] a = $urandom, b = $urandom, c = $urandom;
                logic mx = k[0], sg = k[1], ds = k[2];
                if (k == 4) begin a = 32'h80000000; b = 32'h7FFFFFFF; c = 32'h80000001; end
                issue(ok(mx, 3'(code), ds, sg), a, b, c,
                      code < 4 ? "R4 merge" : (code == 4 || code == 7) ? "R5 acc/pass" : "R6 second cmp", 0);
            end
        end
        issue(ok(1, 3'd3, 0, 0), 32'h000000AB, 0, 32'h11223344, "R4 byte2", 0);
        chk("R4 byte2 literal", result, 32'h11AB3344);
        issue(ok(1, 3'd4, 0, 0), 32'hFFFFFFFF, 0, 32'd2, "R5 wrap", 0);
        chk("R5 wrap literal", result, 32'd1);
    endtask

    task automatic t_dest_sign;
        // primary unsigned, second compare signed and vice versa
        issue(ok(1, 3'd6, 1, 0), 32'h80000000, 32'h1, 32'h7FFFFFFF, "R6 dst signed max", 0);
        chk("R6 literal max", result, 32'h7FFFFFFF);
        issue(ok(1, 3'd5, 0, 1), 32'h7FFFFFFF, 32'h1, 32'h80000000, "R6 dst unsigned min", 0);
        chk("R6 literal min", result, 32'h7FFFFFFF);
    endtask

    task automatic t_unsupported;
        issue(mk(1, 3'd7, 0, 0, 0, 0, 0, 2'b11, 2'b11), 5, 9, 0, "R8 b imm", 1);
        issue(mk(1, 3'd7, 0, 1, 0, 0, 1, 2'b11, 2'b11), 32'h80000000, 3, 0, "R8 sign mix", 1);
        issue(mk(1, 3'd7, 0, 0, 0, 1, 1, 2'b11, 2'b11), 5, 9, 0, "R8 sat", 1);
        issue(mk(0, 3'd7, 0, 0, 0, 0, 1, 2'b10, 2'b11), 5, 9, 0, "R7 fmt a16", 1);
        issue(mk(0, 3'd7, 0, 0, 0, 0, 1, 2'b11, 2'b01), 5, 9, 0, "R7 fmt b8", 1);
        issue(mk(0, 3'd7, 0, 0, 0, 0, 1, 2'b00, 2'b11), 5, 9, 0, "R7 fmt a8", 1);
        begin
            logic [63:0] w = ok(1, 3'd4, 0, 0);
            w[63:57] = 7'b0011100;
            issue(w, 5, 9, 1, "R1 bad opcode", 1);
        end
        issue(ok(1, 3'd4, 0, 0), 5, 9, 1, "R1 good opcode", 0);
    endtask

    task automatic t_idle;
        logic [31:0] keep_r;
        logic        keep_u;
        issue(mk(1, 3'd7, 0, 0, 0, 1, 1, 2'b11, 2'b11), 32'hCAFE, 1, 0, "R10 setup", 1);
        keep_r = result; keep_u = unsupported;
        instr = ok(0, 3'd4, 0, 0); opa = 32'h1; opb = 32'h2; opc = 32'h3;
        repeat (3) @(negedge clk);
        chk("R10 valid low", {31'b0, res_valid}, 32'd0);
        chk("R10 result hold", result, keep_r);
        chk("R10 flag hold", {31'b0, unsupported}, {31'b0, keep_u});
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0; opa = '0; opb = '0; opc = '0;
        t_reset();
        t_primary();
        t_secondary();
        t_dest_sign();
        t_unsupported();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule